// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns parallel audio samples into a serial stream. It drives the bit clock, a frame sync and one data line. A strobe input marks each half period of the bit clock, so the line rate is set by whatever produces that strobe. The block produces no clock of its own. The port can frame data in four ways: I2S, left-justified, DSP-A (a one-bit sync pulse one bit early) and DSP-B (a one-bit sync pulse on the first bit). Each frame holds between one and sixteen slots. Each slot is as wide as the data word, which is 16, 20 or 24 bits. A per-slot mask silences chosen slots. The bit-clock and frame-sync levels can each be inverted.

Samples arrive on a valid/ready handshake, one sample per unmasked slot, and are sent MSB first. If no sample is offered when a slot starts, the slot is sent as zeros and a sticky underrun flag rises. The whole configuration is captured only while the port is disabled. When the port is enabled, it first sends one lead-in bit with no data, so that the early-sync formats have a bit in which to assert their sync.

Top module: `serial_audio_tx`

## Requirements
- R1: With `fmt_sel`=0 (I2S), the frame sync is active low. Counting the lead-in bit as bit 0 of the output stream, it is active for bits k where k mod F < W. Here F is the frame length in bits and W the word length. This places the sync one bit ahead of the first data bit and makes it one slot wide.
- R2: With `fmt_sel`=1 (left-justified), the frame sync is active high, and it is active for bits k ≥ 1 where (k−1) mod F < W. It is aligned with the first data bit and lasts one slot.
- R3: With `fmt_sel`=2 (DSP-A), the frame sync is active high and pulses for exactly one bit, at every k where k mod F = 0. That is one bit before the first data bit of each frame.
- R4: With `fmt_sel`=3 (DSP-B), the frame sync is active high and pulses for exactly one bit, at every k ≥ 1 where (k−1) mod F = 0. That is on the first data bit.
- R5: `wl_sel` sets the word and slot width: 0 gives 16 bits, 1 gives 20, and 2 or 3 give 24. Each sample is taken from the low W bits of `s_data` and sent MSB first.
- R6: `slots_m1` holds the slot count minus one, so a frame is (`slots_m1`+1)·W bits.
- R7: A 1 in bit i of `slot_mask` masks slot i. In a masked slot, `sd_o` and `sd_oe_o` are low and no sample is taken.
- R8: `sclk_inv` and `fs_inv` invert the bit clock and the frame sync independently. While the port is disabled, `sclk_o` rests at the `sclk_inv` level.
- R9: Data and frame sync change only at the edge that moves `sclk_o` to its resting level. They are stable at the opposite edge, where the receiver samples.
- R10: If `s_valid` is low when an unmasked slot starts, that slot is sent as zeros and `underrun_o` goes high. It stays high until the port is disabled, which clears it.
- R11: Format, word length, slot count, mask and polarities are captured only while `port_en` is low. Changes to them while the port is enabled have no effect.
- R12: After reset, and from the cycle after `port_en` falls: `sd_o`, `sd_oe_o`, `s_ready` and `underrun_o` are low, and the frame sync is at its inactive level.
- R13: `s_ready` is high for a single cycle at the start of each unmasked slot. Samples are accepted in order, one per unmasked slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; configuration is captured while low |
| bit_stb | input | 1 | Half-bit-period strobe |
| fmt_sel | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| wl_sel | input | 2 | Word length select |
| slots_m1 | input | 4 | Slots per frame minus one |
| slot_mask | input | 16 | Per-slot mask, 1 = silent |
| sclk_inv | input | 1 | Invert bit clock |
| fs_inv | input | 1 | Invert frame sync |
| s_data | input | 24 | Sample, right-aligned |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted this cycle when valid |
| sclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Data driver enable |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
`sclk_o`, `fs_o`, `sd_o` and `sd_oe_o` all change in the cycle after the clock edge that consumes a strobe, and `s_ready` is combinational in the strobe cycle that ends a slot. The bench therefore does not count cycles for the serial outputs. It acts as a receiver: it samples frame sync and data one time unit after each clock edge that moves `sclk_o` away from its resting level, and it checks that data never moves in any other cycle. `underrun_o` rises on the same edge that loads the empty slot. It is checked after the capture and again two cycles after the port is disabled. `s_ready` is counted at falling clock edges, after the strobe has settled.

// File: rtl/satx_pkg.sv
package satx_pkg;

  localparam int SLOT_IDX_W = 4;
  localparam int SLOT_CNT   = 1 << SLOT_IDX_W;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e                  fmt;
    logic [1:0]            wl_sel;
    logic [SLOT_IDX_W-1:0] slots_m1;
    logic                  sclk_inv;
    logic                  fs_inv;
  } cfg_t;

  // index of the last bit of a slot for a word length code
  function automatic logic [4:0] last_bit_index(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd15;
      2'd1:    return 5'd19;
      default: return 5'd23;
    endcase
  endfunction

  // active-high frame sync for the bit currently on the line
  function automatic logic frame_sync_active(input fmt_e fmt, input logic lead,
                                             input logic first_slot, input logic last_slot,
                                             input logic first_bit, input logic last_bit);
    case (fmt)
      FMT_I2S:  return (!lead && first_slot && !last_bit) || (last_slot && last_bit);
      FMT_LJ:   return !lead && first_slot;
      FMT_DSPA: return last_slot && last_bit;
      default:  return !lead && first_slot && first_bit;
    endcase
  endfunction

endpackage

// File: rtl/satx_cfg_hold.sv
module satx_cfg_hold
  import satx_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  cfg_t              cfg_in,
  input  logic [MASK_W-1:0] mask_in,
  output cfg_t              cfg_q,
  output logic [MASK_W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (!port_en) begin
      cfg_q  <= cfg_in;
      mask_q <= mask_in;
    end
  end

endmodule

// File: rtl/satx_framer.sv
module satx_framer #(
  parameter int BIT_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              bit_stb,
  input  logic [BIT_W-1:0]  last_bit_run,
  input  logic [SLOT_W-1:0] last_slot_run,
  input  logic [BIT_W-1:0]  last_bit_idle,
  input  logic [SLOT_W-1:0] last_slot_idle,
  output logic              phase_o,
  output logic              lead_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              fall_evt_o,
  output logic              load_evt_o
);

  logic              phase_q;
  logic              lead_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_end;

  assign slot_end    = lead_q || (bit_q == last_bit_run);
  assign next_slot_o = (lead_q || slot_q == last_slot_run) ? '0 : slot_q + 1'b1;
  assign fall_evt_o  = port_en && bit_stb && phase_q;
  assign load_evt_o  = fall_evt_o && slot_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b1;
      bit_q   <= '0;
      slot_q  <= '0;
    end else if (!port_en) begin
      phase_q <= 1'b0;
      lead_q  <= 1'b1;
      bit_q   <= last_bit_idle;
      slot_q  <= last_slot_idle;
    end else if (bit_stb) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        lead_q  <= 1'b0;
        if (slot_end) begin
          bit_q  <= '0;
          slot_q <= next_slot_o;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign lead_o  = lead_q;
  assign bit_o   = bit_q;
  assign slot_o  = slot_q;

endmodule

// File: rtl/satx_shifter.sv
module satx_shifter #(
  parameter int MAX_WL = 24,
  parameter int BIT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              load_evt,
  input  logic              shift_evt,
  input  logic              take_ok,
  input  logic              s_valid,
  input  logic [MAX_WL-1:0] s_data,
  input  logic [BIT_W-1:0]  last_bit,
  output logic              msb_o,
  output logic              underrun_o
);

  logic [MAX_WL-1:0] sh_q;
  logic              und_q;
  logic [BIT_W-1:0]  pad;
  logic [MAX_WL-1:0] aligned;

  assign pad     = BIT_W'(MAX_WL - 1) - last_bit;
  assign aligned = s_data << pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      und_q <= 1'b0;
    end else if (!port_en) begin
      sh_q  <= '0;
      und_q <= 1'b0;
    end else if (load_evt) begin
      if (!take_ok) begin
        sh_q <= '0;
      end else if (s_valid) begin
        sh_q <= aligned;
      end else begin
        sh_q  <= '0;
        und_q <= 1'b1;
      end
    end else if (shift_evt) begin
      sh_q <= sh_q << 1;
    end
  end

  assign msb_o      = sh_q[MAX_WL-1];
  assign underrun_o = und_q;

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import satx_pkg::*;
#(
  parameter int MAX_WL = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  port_en,
  input  logic                  bit_stb,
  input  logic [1:0]            fmt_sel,
  input  logic [1:0]            wl_sel,
  input  logic [SLOT_IDX_W-1:0] slots_m1,
  input  logic [SLOT_CNT-1:0]   slot_mask,
  input  logic                  sclk_inv,
  input  logic                  fs_inv,
  input  logic [MAX_WL-1:0]     s_data,
  input  logic                  s_valid,
  output logic                  s_ready,
  output logic                  sclk_o,
  output logic                  fs_o,
  output logic                  sd_o,
  output logic                  sd_oe_o,
  output logic                  underrun_o
);

  localparam int BIT_W  = $clog2(MAX_WL);
  localparam int SLOT_W = SLOT_IDX_W;
  localparam int CFG_W  = $bits(cfg_t) + SLOT_CNT;

  cfg_t                cfg_in;
  cfg_t                cfg_q;
  logic [SLOT_CNT-1:0] mask_q;
  logic [BIT_W-1:0]    last_bit_run;
  logic [BIT_W-1:0]    last_bit_idle;
  logic                phase;
  logic                lead;
  logic [BIT_W-1:0]    bit_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [SLOT_W-1:0]   next_slot;
  logic                fall_evt;
  logic                load_evt;
  logic                next_masked;
  logic                slot_masked;
  logic                sh_msb;
  logic                fs_act;
  logic [CFG_W-1:0]    cfg_flat;

  assign cfg_in = '{fmt: fmt_e'(fmt_sel), wl_sel: wl_sel, slots_m1: slots_m1,
                    sclk_inv: sclk_inv, fs_inv: fs_inv};

  satx_cfg_hold #(.MASK_W(SLOT_CNT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .port_en (port_en),
    .cfg_in  (cfg_in),
    .mask_in (slot_mask),
    .cfg_q   (cfg_q),
    .mask_q  (mask_q)
  );

  assign last_bit_run  = BIT_W'(last_bit_index(cfg_q.wl_sel));
  assign last_bit_idle = BIT_W'(last_bit_index(wl_sel));
  assign cfg_flat      = {cfg_q, mask_q};

  satx_framer #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_framer (
    .clk            (clk),
    .rst_n          (rst_n),
    .port_en        (port_en),
    .bit_stb        (bit_stb),
    .last_bit_run   (last_bit_run),
    .last_slot_run  (cfg_q.slots_m1),
    .last_bit_idle  (last_bit_idle),
    .last_slot_idle (slots_m1),
    .phase_o        (phase),
    .lead_o         (lead),
    .bit_o          (bit_q),
    .slot_o         (slot_q),
    .next_slot_o    (next_slot),
    .fall_evt_o     (fall_evt),
    .load_evt_o     (load_evt)
  );

  assign next_masked = mask_q[next_slot];
  assign slot_masked = mask_q[slot_q];
  assign s_ready     = load_evt && !next_masked;

  satx_shifter #(.MAX_WL(MAX_WL), .BIT_W(BIT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .load_evt   (load_evt),
    .shift_evt  (fall_evt && !load_evt),
    .take_ok    (!next_masked),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .last_bit   (last_bit_run),
    .msb_o      (sh_msb),
    .underrun_o (underrun_o)
  );

  assign fs_act  = port_en && frame_sync_active(cfg_q.fmt, lead,
                                                slot_q == '0, slot_q == cfg_q.slots_m1,
                                                bit_q == '0, bit_q == last_bit_run);
  assign sd_oe_o = port_en && !lead && !slot_masked;
  assign sd_o    = sd_oe_o && sh_msb;
  assign sclk_o  = (port_en && phase) ^ cfg_q.sclk_inv;
  assign fs_o    = fs_act ^ cfg_q.fs_inv ^ (cfg_q.fmt == FMT_I2S);

endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk #(
  parameter int SLOT_W = 4,
  parameter int BIT_W  = 5,
  parameter int CFG_W  = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              fall_evt,
  input logic              s_ready,
  input logic              sd_o,
  input logic              fs_o,
  input logic              sd_oe_o,
  input logic              underrun_o,
  input logic [SLOT_W-1:0] slot_q,
  input logic [SLOT_W-1:0] slots_m1_q,
  input logic [BIT_W-1:0]  bit_q,
  input logic [BIT_W-1:0]  last_bit_q,
  input logic [CFG_W-1:0]  cfg_flat
);

  // R9
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !fall_evt) |=> (!port_en || $stable(sd_o)));

  // R9
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !fall_evt) |=> (!port_en || $stable(fs_o)));

  // R13
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && port_en) |=> underrun_o);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!sd_oe_o && !underrun_o));

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |=> $stable(cfg_flat));

  // R6
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> (slot_q <= slots_m1_q));

  // R5
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_en |-> (bit_q <= last_bit_q));

endmodule

bind serial_audio_tx serial_audio_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_en    (port_en),
  .fall_evt   (fall_evt),
  .s_ready    (s_ready),
  .sd_o       (sd_o),
  .fs_o       (fs_o),
  .sd_oe_o    (sd_oe_o),
  .underrun_o (underrun_o),
  .slot_q     (slot_q),
  .slots_m1_q (cfg_q.slots_m1),
  .bit_q      (bit_q),
  .last_bit_q (last_bit_run),
  .cfg_flat   (cfg_flat)
);

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        bit_stb = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  wl_sel = 2'd0;
  logic [3:0]  slots_m1 = 4'd0;
  logic [15:0] slot_mask = 16'h0;
  logic        sclk_inv = 1'b0;
  logic        fs_inv = 1'b0;
  logic [23:0] s_data;
  logic        s_valid;
  logic        s_ready, sclk_o, fs_o, sd_o, sd_oe_o, underrun_o;

  int  checks = 0;
  int  errors = 0;
  int  idx = 0;
  int  rdy_cnt = 0;
  int  cur_w = 16;
  int  tdiv = 1;
  int  tcnt = 0;
  bit  feed = 1'b0;
  bit  idx_clr = 1'b1;
  bit  take = 1'b0;

  // fields: fmt[29:28] wl[27:26] slots_m1[25:22] mask[21:6] sclk_inv[5] fs_inv[4] strobe_div[3:0]
  localparam logic [29:0] VECS [0:7] = '{
    {2'd0, 2'd0, 4'd1,  16'h0000, 1'b0, 1'b0, 4'd1},
    {2'd1, 2'd2, 4'd1,  16'h0000, 1'b1, 1'b0, 4'd1},
    {2'd2, 2'd1, 4'd3,  16'h0000, 1'b0, 1'b1, 4'd2},
    {2'd3, 2'd0, 4'd3,  16'h0002, 1'b0, 1'b0, 4'd1},
    {2'd0, 2'd2, 4'd1,  16'h0000, 1'b1, 1'b1, 4'd3},
    {2'd2, 2'd0, 4'd12, 16'h0A05, 1'b0, 1'b0, 4'd1},
    {2'd1, 2'd1, 4'd0,  16'h0000, 1'b0, 1'b0, 4'd1},
    {2'd3, 2'd3, 4'd2,  16'h0004, 1'b0, 1'b1, 4'd1}
  };

  function automatic logic [23:0] samp(input int i, input int w);
    logic [31:0] x;
    x = i * 32'h9E37 + 32'h5A3C1;
    x = x ^ (x >> 5);
    return x[23:0] & 24'((32'd1 << w) - 1);
  endfunction

  assign s_valid = feed;
  assign s_data  = samp(idx, cur_w);

  serial_audio_tx uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bit_stb(bit_stb),
    .fmt_sel(fmt_sel), .wl_sel(wl_sel), .slots_m1(slots_m1), .slot_mask(slot_mask),
    .sclk_inv(sclk_inv), .fs_inv(fs_inv), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .sclk_o(sclk_o), .fs_o(fs_o), .sd_o(sd_o),
    .sd_oe_o(sd_oe_o), .underrun_o(underrun_o)
  );

  // strobe generator, updated away from the edge
  always @(posedge clk) begin
    #2;
    tcnt    = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    bit_stb = (tcnt == 0);
  end

  always @(negedge clk) begin
    take = s_valid && s_ready;
    if (idx_clr) rdy_cnt = 0;
    else if (s_ready) rdy_cnt = rdy_cnt + 1;
  end

  always @(posedge clk) begin
    #1;
    if (idx_clr) idx = 0;
    else if (take) idx = idx + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [29:0] v, input bit fd, input bit perturb);
    logic [1:0]  fmt;
    logic [15:0] mask;
    logic        binv, finv, prev, prev_sd, fsn, efs, esd, eoe;
    logic [23:0] sv;
    int W, NS, F, nbits, k, sn, p, b, sl, guard;
    int e_fs, e_sd, e_oe, e_r9, und_early;
    string ftag;
    fmt  = v[29:28];
    mask = v[21:6];
    binv = v[5];
    finv = v[4];
    W    = (v[27:26] == 2'd0) ? 16 : (v[27:26] == 2'd1) ? 20 : 24;
    NS   = int'(v[25:22]) + 1;
    F    = W * NS;
    nbits = 2 * F + 2;
    case (fmt)
      2'd0: ftag = "R1";
      2'd1: ftag = "R2";
      2'd2: ftag = "R3";
      default: ftag = "R4";
    endcase
    @(negedge clk);
    port_en = 1'b0; fmt_sel = fmt; wl_sel = v[27:26]; slots_m1 = v[25:22];
    slot_mask = mask; sclk_inv = binv; fs_inv = finv; tdiv = int'(v[3:0]);
    feed = fd; cur_w = W; idx_clr = 1'b1;
    repeat (4) @(negedge clk);
    fsn = fs_o ^ finv ^ (fmt == 2'd0);
    // R8 R12: resting levels while disabled
    check(sclk_o == binv && fsn == 1'b0 && sd_oe_o == 1'b0, "R8 R12", "idle sclk",
          int'(sclk_o), int'(binv));
    idx_clr = 1'b0;
    port_en = 1'b1;
    prev = sclk_o; prev_sd = sd_o;
    k = 0; sn = -1; guard = 0;
    e_fs = 0; e_sd = 0; e_oe = 0; e_r9 = 0; und_early = 0;
    while (k < nbits && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      if (sd_o != prev_sd && !(prev != binv && sclk_o == binv)) e_r9++;
      if (prev == binv && sclk_o != binv) begin
        if (k == 0) begin
          eoe = 1'b0; esd = 1'b0;
          if (underrun_o) und_early++;
        end else begin
          p = k - 1; b = p % W; sl = (p / W) % NS;
          if (b == 0 && !mask[sl]) sn++;
          eoe = !mask[sl];
          sv  = samp(sn, W);
          esd = eoe && fd && sv[W-1-b];
        end
        case (fmt)
          2'd0: efs = (k % F) < W;
          2'd1: efs = (k >= 1) && (((k - 1) % F) < W);
          2'd2: efs = (k % F) == 0;
          default: efs = (k >= 1) && (((k - 1) % F) == 0);
        endcase
        fsn = fs_o ^ finv ^ (fmt == 2'd0);
        if (fsn != efs) e_fs++;
        if (sd_o != esd) e_sd++;
        if (sd_oe_o != eoe) e_oe++;
        k++;
        if (perturb && k == 4) begin
          fmt_sel = fmt + 2'd1; wl_sel = v[27:26] ^ 2'd1; slots_m1 = v[25:22] ^ 4'h3;
          slot_mask = ~mask; sclk_inv = ~binv; fs_inv = ~finv;
        end
      end
      prev = sclk_o; prev_sd = sd_o;
    end
    check(k == nbits, "R6", "bits captured", k, nbits);
    check(e_fs == 0, {ftag, " R6"}, "frame sync mismatches", e_fs, 0);
    check(e_sd == 0, "R5", "data mismatches", e_sd, 0);
    check(e_oe == 0, "R7", "driver enable mismatches", e_oe, 0);
    check(e_r9 == 0, "R9", "data moved off the launch edge", e_r9, 0);
    check(rdy_cnt == (fd ? sn + 1 : sn + 1), "R13", "ready pulses", rdy_cnt, sn + 1);
    if (perturb)
      check(e_fs == 0 && e_sd == 0 && e_oe == 0, "R11", "live config change leaked",
            e_fs + e_sd + e_oe, 0);
    if (fd || sn < 0) begin
      check(underrun_o == 1'b0, "R10", "underrun with data supplied", int'(underrun_o), 0);
    end else begin
      check(und_early == 0, "R10", "underrun before first slot", und_early, 0);
      check(underrun_o == 1'b1, "R10", "underrun flag", int'(underrun_o), 1);
    end
    port_en = 1'b0;
    repeat (2) @(negedge clk);
    check(underrun_o == 1'b0 && sd_oe_o == 1'b0 && s_ready == 1'b0, "R10 R12",
          "state after disable", int'(underrun_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state (defaults select I2S, so the inactive sync level is high)
    check(sclk_o == 1'b0 && fs_o == 1'b1 && sd_o == 1'b0 && sd_oe_o == 1'b0 &&
          s_ready == 1'b0 && underrun_o == 1'b0, "R12", "reset outputs",
          int'({sclk_o, fs_o, sd_o, sd_oe_o, s_ready, underrun_o}), 16);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 8; i++) run_vec(VECS[i], 1'b1, 1'b0);

    // R10: no samples offered, slots go out as zeros
    run_vec(VECS[0], 1'b0, 1'b0);
    run_vec(VECS[5], 1'b0, 1'b0);
    // R7: every slot masked, nothing taken and nothing driven
    run_vec({2'd1, 2'd0, 4'd1, 16'hFFFF, 1'b0, 1'b0, 4'd1}, 1'b1, 1'b0);
    // R11: configuration inputs change mid-run
    run_vec(VECS[3], 1'b1, 1'b1);
    run_vec(VECS[1], 1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule